// File: doc/BRIEF.md
# Surface Copy Planner

This block takes one rectangle copy request between two pixel surfaces and turns it into a sequence of sub-commands for a downstream copy engine. The request names the memory layout of each surface (row-linear or swizzled), the destination surface size, the bytes per pixel, the base offsets and pitches of both surfaces, the source and destination corners, and the width and height to copy. From layout, size and alignment the block picks one of three engines: a row-linear mover, a swizzling blitter, or a per-pixel fallback.

The block then cuts the rectangle to the limits of the chosen engine. The linear mover takes at most 2047 rows per command. The swizzling blitter takes tiles of at most 1024 by 1024. The fallback gets the whole rectangle in one command. Each piece goes out on a valid/ready port, together with its destination corner, size and starting byte offsets. A one-cycle done pulse marks the end of a request.

The control is a three-state machine. **IDLE** holds `req_ready` high. On an accepted request it takes the **ZERO_SIZE** transition to **DONE** when the width or height is zero, and otherwise the **START** transition to **EMIT**. **EMIT** drives `cmd_valid`. On each accepted piece it either stays in EMIT and advances (the **NEXT_PIECE** transition) or, on the last piece, takes the **LAST_PIECE** transition to **DONE**. **DONE** raises `done` for one cycle and takes the **RETIRE** transition back to IDLE.

Top module: `surf_copy_planner`

## Requirements
- R1: The linear engine (`cmd_path` = 0) is chosen when both layout bits are 0 (layout bit: 0 row-linear, 1 swizzled), when the destination surface width is 2 or less, or when the destination surface height is 1 or less.
- R2: If R1 does not apply, the swizzle engine (`cmd_path` = 1) is chosen when the source is linear, the destination is swizzled, the bytes per pixel is not 1, and the low 6 bits of the destination base are zero.
- R3: Every other request goes to the fallback engine (`cmd_path` = 2) as one command of the full width and height, with the source and destination base offsets passed through unchanged.
- R4: A linear copy is issued as chunks of the full width and at most 2047 rows each, with rows in increasing order. Every chunk except the last has exactly 2047 rows.
- R5: A linear chunk starting at row offset y carries a source offset of src_base + (sy+y)·src_pitch + sx·cpp and a destination offset of dst_base + (dy+y)·dst_pitch + dx·cpp. The offsets therefore advance by pitch times the rows of the previous chunk.
- R6: A swizzle copy is issued as tiles of at most 1024×1024, clipped at the right and bottom edges. The x position runs in the inner loop and the y position in the outer loop.
- R7: The size reported for each swizzle tile is its clipped width and height, each rounded up to an even number.
- R8: A swizzle tile at offset (x, y) carries a source offset of src_base + (sy+y)·src_pitch + (sx+x)·cpp, and its destination offset is the destination base.
- R9: Every command carries the destination corner (dx+x, dy+y) of its piece.
- R10: A request with zero width or zero height issues no command and pulses `done` in the cycle after acceptance.
- R11: `req_ready` is high only in IDLE. `done` is high for exactly one cycle, the cycle after the last command is accepted. A new request is accepted no earlier than the cycle after `done`.
- R12: While `cmd_valid` is high and `cmd_ready` is low, all command fields hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted (IDLE) |
| req_src_swz | input | 1 | Source layout, 1 = swizzled |
| req_dst_swz | input | 1 | Destination layout, 1 = swizzled |
| req_dst_width | input | DIMW | Destination surface width |
| req_dst_height | input | DIMW | Destination surface height |
| req_cpp | input | 3 | Bytes per pixel |
| req_src_base | input | OFFW | Source surface base offset |
| req_dst_base | input | OFFW | Destination surface base offset |
| req_src_pitch | input | PW | Source row pitch in bytes |
| req_dst_pitch | input | PW | Destination row pitch in bytes |
| req_sx | input | CW | Source corner x |
| req_sy | input | CW | Source corner y |
| req_dx | input | CW | Destination corner x |
| req_dy | input | CW | Destination corner y |
| req_w | input | CW | Copy width in pixels |
| req_h | input | CW | Copy height in pixels |
| cmd_valid | output | 1 | Sub-command offered |
| cmd_ready | input | 1 | Sub-command taken |
| cmd_path | output | 2 | Engine: 0 linear, 1 swizzle, 2 fallback |
| cmd_x | output | CW | Destination x of the piece |
| cmd_y | output | CW | Destination y of the piece |
| cmd_w | output | CW | Piece width |
| cmd_h | output | CW | Piece height |
| cmd_src_off | output | OFFW | Source start byte offset |
| cmd_dst_off | output | OFFW | Destination start byte offset |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Two things can fall in the same cycle: the handshake of the last piece of one request, and a second request that is already waiting on `req_valid`. To set this up, the bench presents the next request immediately after the first is accepted and keeps it valid for the whole job. It then checks three things. `req_ready` stays low in every EMIT cycle and in the DONE cycle. The first job's commands all carry the fields latched at its own acceptance. The second request is taken only after `done`, and its pieces come out complete. Backpressure on the final piece is covered separately: the fields must hold steady and `done` must wait for the handshake.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        PATH_LIN = 2'd0,
        PATH_SWZ = 2'd1,
        PATH_FBK = 2'd2
    } path_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } state_e;

endpackage

// File: rtl/scp_path_sel.sv
module scp_path_sel
    import scp_pkg::*;
#(
    parameter int DIMW       = 16,
    parameter int ALIGN_BITS = 6
) (
    input  logic                  src_swz,
    input  logic                  dst_swz,
    input  logic [DIMW-1:0]       dst_width,
    input  logic [DIMW-1:0]       dst_height,
    input  logic [2:0]            cpp,
    input  logic [ALIGN_BITS-1:0] dst_base_lo,
    output path_e                 path
);

    logic use_lin;
    logic use_swz;

    always_comb begin
        use_lin = (!src_swz && !dst_swz)
               || (dst_width  <= DIMW'(2))
               || (dst_height <= DIMW'(1));
        use_swz = !src_swz && dst_swz && (cpp != 3'd1)
               && (dst_base_lo == '0);
        if (use_lin)
            path = PATH_LIN;
        else if (use_swz)
            path = PATH_SWZ;
        else
            path = PATH_FBK;
    end

endmodule

// File: rtl/scp_offset.sv
module scp_offset #(
    parameter int CW   = 16,
    parameter int PW   = 16,
    parameter int OFFW = 32
) (
    input  logic [OFFW-1:0] base,
    input  logic [CW-1:0]   row,
    input  logic [CW-1:0]   col,
    input  logic [PW-1:0]   pitch,
    input  logic [2:0]      cpp,
    output logic [OFFW-1:0] off
);

    assign off = base + OFFW'(row) * OFFW'(pitch) + OFFW'(col) * OFFW'(cpp);

endmodule

// File: rtl/scp_walker.sv
module scp_walker
    import scp_pkg::*;
#(
    parameter int CW         = 16,
    parameter int CHUNK_ROWS = 2047,
    parameter int TILE_W     = 1024,
    parameter int TILE_H     = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  path_e         path_in,
    input  logic [CW-1:0] w_in,
    input  logic [CW-1:0] h_in,
    output logic          req_ready,
    input  logic          cmd_ready,
    output logic          cmd_valid,
    output path_e         path_q,
    output logic [CW-1:0] x_q,
    output logic [CW-1:0] y_q,
    output logic [CW-1:0] piece_w,
    output logic [CW-1:0] piece_h,
    output logic          done
);

    localparam logic [CW-1:0] CHUNK_C = CW'(CHUNK_ROWS);
    localparam logic [CW-1:0] TW_C    = CW'(TILE_W);
    localparam logic [CW-1:0] TH_C    = CW'(TILE_H);

    state_e        state, nxt;
    logic [CW-1:0] w_q, h_q;
    logic [CW-1:0] rem_w, rem_h;
    logic          accept, fire, last;

    assign accept = req_valid && req_ready;
    assign fire   = cmd_valid && cmd_ready;
    assign rem_w  = w_q - x_q;
    assign rem_h  = h_q - y_q;

    // piece geometry for the current position
    always_comb begin
        unique case (path_q)
            PATH_LIN: begin
                piece_w = w_q;
                piece_h = (rem_h > CHUNK_C) ? CHUNK_C : rem_h;
                last    = (rem_h <= CHUNK_C);
            end
            PATH_SWZ: begin
                piece_w = (rem_w > TW_C) ? TW_C : rem_w;
                piece_h = (rem_h > TH_C) ? TH_C : rem_h;
                last    = (rem_w <= TW_C) && (rem_h <= TH_C);
            end
            default: begin
                piece_w = w_q;
                piece_h = h_q;
                last    = 1'b1;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // transitions: START, ZERO_SIZE, NEXT_PIECE, LAST_PIECE, RETIRE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (accept)
                         nxt = ((w_in == '0) || (h_in == '0)) ? ST_DONE : ST_EMIT;
            ST_EMIT: if (fire && last)
                         nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from the state
    always_comb begin
        req_ready = 1'b0;
        cmd_valid = 1'b0;
        done      = 1'b0;
        unique case (state)
            ST_IDLE: req_ready = 1'b1;
            ST_EMIT: cmd_valid = 1'b1;
            ST_DONE: done      = 1'b1;
            default: ;
        endcase
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            path_q <= PATH_LIN;
            w_q    <= '0;
            h_q    <= '0;
            x_q    <= '0;
            y_q    <= '0;
        end else if (accept) begin
            path_q <= path_in;
            w_q    <= w_in;
            h_q    <= h_in;
            x_q    <= '0;
            y_q    <= '0;
        end else if (fire && !last) begin
            if (path_q == PATH_SWZ) begin
                if (rem_w <= TW_C) begin
                    x_q <= '0;
                    y_q <= y_q + TH_C;
                end else begin
                    x_q <= x_q + TW_C;
                end
            end else begin
                y_q <= y_q + piece_h;
            end
        end
    end

    assert_zero_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        accept && ((w_in == '0) || (h_in == '0)) |=> done && !cmd_valid);

    assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fire && last |=> done);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && req_ready && !cmd_valid);

    assert_chunk_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (path_q == PATH_LIN) |-> (piece_h <= CHUNK_C) && (piece_h != '0));

    assert_tile_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (path_q == PATH_SWZ) |-> (piece_w <= TW_C) && (piece_h <= TH_C)
                                              && (piece_w != '0) && (piece_h != '0));

endmodule

// File: rtl/surf_copy_planner.sv
module surf_copy_planner
    import scp_pkg::*;
#(
    parameter int CW         = 16,
    parameter int DIMW       = 16,
    parameter int PW         = 16,
    parameter int OFFW       = 32,
    parameter int CHUNK_ROWS = 2047,
    parameter int TILE_W     = 1024,
    parameter int TILE_H     = 1024,
    parameter int ALIGN_BITS = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_src_swz,
    input  logic            req_dst_swz,
    input  logic [DIMW-1:0] req_dst_width,
    input  logic [DIMW-1:0] req_dst_height,
    input  logic [2:0]      req_cpp,
    input  logic [OFFW-1:0] req_src_base,
    input  logic [OFFW-1:0] req_dst_base,
    input  logic [PW-1:0]   req_src_pitch,
    input  logic [PW-1:0]   req_dst_pitch,
    input  logic [CW-1:0]   req_sx,
    input  logic [CW-1:0]   req_sy,
    input  logic [CW-1:0]   req_dx,
    input  logic [CW-1:0]   req_dy,
    input  logic [CW-1:0]   req_w,
    input  logic [CW-1:0]   req_h,
    output logic            cmd_valid,
    input  logic            cmd_ready,
    output logic [1:0]      cmd_path,
    output logic [CW-1:0]   cmd_x,
    output logic [CW-1:0]   cmd_y,
    output logic [CW-1:0]   cmd_w,
    output logic [CW-1:0]   cmd_h,
    output logic [OFFW-1:0] cmd_src_off,
    output logic [OFFW-1:0] cmd_dst_off,
    output logic            done
);

    path_e           sel_path, path_q;
    logic [CW-1:0]   x_q, y_q, piece_w, piece_h;
    logic            accept;
    logic [2:0]      cpp_q;
    logic [OFFW-1:0] src_base_q, dst_base_q, src_lin, dst_lin;
    logic [PW-1:0]   src_pitch_q, dst_pitch_q;
    logic [CW-1:0]   sx_q, sy_q, dx_q, dy_q;
    logic [CW-1:0]   src_row, src_col, dst_row, dst_col;

    assign accept = req_valid && req_ready;

    scp_path_sel #(.DIMW(DIMW), .ALIGN_BITS(ALIGN_BITS)) u_sel (
        .src_swz     (req_src_swz),
        .dst_swz     (req_dst_swz),
        .dst_width   (req_dst_width),
        .dst_height  (req_dst_height),
        .cpp         (req_cpp),
        .dst_base_lo (req_dst_base[ALIGN_BITS-1:0]),
        .path        (sel_path)
    );

    scp_walker #(.CW(CW), .CHUNK_ROWS(CHUNK_ROWS), .TILE_W(TILE_W), .TILE_H(TILE_H)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .path_in   (sel_path),
        .w_in      (req_w),
        .h_in      (req_h),
        .req_ready (req_ready),
        .cmd_ready (cmd_ready),
        .cmd_valid (cmd_valid),
        .path_q    (path_q),
        .x_q       (x_q),
        .y_q       (y_q),
        .piece_w   (piece_w),
        .piece_h   (piece_h),
        .done      (done)
    );

    // request fields captured at acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpp_q       <= '0;
            src_base_q  <= '0;
            dst_base_q  <= '0;
            src_pitch_q <= '0;
            dst_pitch_q <= '0;
            sx_q        <= '0;
            sy_q        <= '0;
            dx_q        <= '0;
            dy_q        <= '0;
        end else if (accept) begin
            cpp_q       <= req_cpp;
            src_base_q  <= req_src_base;
            dst_base_q  <= req_dst_base;
            src_pitch_q <= req_src_pitch;
            dst_pitch_q <= req_dst_pitch;
            sx_q        <= req_sx;
            sy_q        <= req_sy;
            dx_q        <= req_dx;
            dy_q        <= req_dy;
        end
    end

    assign src_row = sy_q + y_q;
    assign src_col = sx_q + x_q;
    assign dst_row = dy_q + y_q;
    assign dst_col = dx_q + x_q;

    scp_offset #(.CW(CW), .PW(PW), .OFFW(OFFW)) u_src_off (
        .base (src_base_q), .row (src_row), .col (src_col),
        .pitch(src_pitch_q), .cpp (cpp_q), .off (src_lin)
    );

    scp_offset #(.CW(CW), .PW(PW), .OFFW(OFFW)) u_dst_off (
        .base (dst_base_q), .row (dst_row), .col (dst_col),
        .pitch(dst_pitch_q), .cpp (cpp_q), .off (dst_lin)
    );

    // command fields per engine
    always_comb begin
        cmd_path = path_q;
        cmd_x    = dst_col;
        cmd_y    = dst_row;
        unique case (path_q)
            PATH_LIN: begin
                cmd_w       = piece_w;
                cmd_h       = piece_h;
                cmd_src_off = src_lin;
                cmd_dst_off = dst_lin;
            end
            PATH_SWZ: begin
                cmd_w       = piece_w + CW'(piece_w[0]);
                cmd_h       = piece_h + CW'(piece_h[0]);
                cmd_src_off = src_lin;
                cmd_dst_off = dst_base_q;
            end
            default: begin
                cmd_w       = piece_w;
                cmd_h       = piece_h;
                cmd_src_off = src_base_q;
                cmd_dst_off = dst_base_q;
            end
        endcase
    end

    assert_hold_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_path) && $stable(cmd_x)
            && $stable(cmd_y) && $stable(cmd_w) && $stable(cmd_h)
            && $stable(cmd_src_off) && $stable(cmd_dst_off));

    assert_even_tile_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && (cmd_path == 2'd1) |-> !cmd_w[0] && !cmd_h[0]);

    assert_no_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !req_ready);

endmodule

// File: tb/surf_copy_planner_bench.sv
`timescale 1ns/1ps
module surf_copy_planner_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_src_swz = 1'b0, req_dst_swz = 1'b0;
    logic [15:0] req_dst_width = '0, req_dst_height = '0;
    logic [2:0]  req_cpp = '0;
    logic [31:0] req_src_base = '0, req_dst_base = '0;
    logic [15:0] req_src_pitch = '0, req_dst_pitch = '0;
    logic [15:0] req_sx = '0, req_sy = '0, req_dx = '0, req_dy = '0, req_w = '0, req_h = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [1:0]  cmd_path;
    logic [15:0] cmd_x, cmd_y, cmd_w, cmd_h;
    logic [31:0] cmd_src_off, cmd_dst_off;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;

    int exp_n, got_n;
    int          e_path[64], e_x[64], e_y[64], e_w[64], e_h[64];
    logic [31:0] e_so[64], e_do[64];
    int          g_path[64], g_x[64], g_y[64], g_w[64], g_h[64];
    logic [31:0] g_so[64], g_do[64];

    always #10 clk = ~clk;

    surf_copy_planner u_surf_copy_planner (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_src_swz(req_src_swz), .req_dst_swz(req_dst_swz),
        .req_dst_width(req_dst_width), .req_dst_height(req_dst_height),
        .req_cpp(req_cpp), .req_src_base(req_src_base), .req_dst_base(req_dst_base),
        .req_src_pitch(req_src_pitch), .req_dst_pitch(req_dst_pitch),
        .req_sx(req_sx), .req_sy(req_sy), .req_dx(req_dx), .req_dy(req_dy),
        .req_w(req_w), .req_h(req_h), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_path(cmd_path), .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .cmd_src_off(cmd_src_off), .cmd_dst_off(cmd_dst_off), .done(done)
    );

    task automatic check(input string req, input string what, input longint act, input longint expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic set_req(input bit ss, input bit ds, input int dw, input int dh, input int cpp,
                           input int sb, input int db, input int sp, input int dp,
                           input int sx, input int sy, input int dx, input int dy,
                           input int w, input int h);
        req_src_swz = ss;  req_dst_swz = ds;
        req_dst_width = 16'(dw); req_dst_height = 16'(dh); req_cpp = 3'(cpp);
        req_src_base = 32'(sb); req_dst_base = 32'(db);
        req_src_pitch = 16'(sp); req_dst_pitch = 16'(dp);
        req_sx = 16'(sx); req_sy = 16'(sy); req_dx = 16'(dx); req_dy = 16'(dy);
        req_w = 16'(w); req_h = 16'(h);
    endtask

    task automatic push_exp(input int p, input int x, input int y, input int w, input int h,
                            input logic [31:0] so, input logic [31:0] dof);
        if (exp_n < 64) begin
            e_path[exp_n] = p; e_x[exp_n] = x; e_y[exp_n] = y; e_w[exp_n] = w; e_h[exp_n] = h;
            e_so[exp_n] = so; e_do[exp_n] = dof;
        end
        exp_n++;
    endtask

    // reference model built from the requirements, reads the request currently on the ports
    task automatic model();
        int p, w, h, cpp;
        int sb, db, sp, dp, sx, sy, dx, dy;
        w = int'(req_w); h = int'(req_h); cpp = int'(req_cpp);
        sb = int'(req_src_base); db = int'(req_dst_base);
        sp = int'(req_src_pitch); dp = int'(req_dst_pitch);
        sx = int'(req_sx); sy = int'(req_sy); dx = int'(req_dx); dy = int'(req_dy);
        exp_n = 0;
        if ((!req_src_swz && !req_dst_swz) || req_dst_width <= 2 || req_dst_height <= 1)
            p = 0;
        else if (!req_src_swz && req_dst_swz && cpp != 1 && (req_dst_base % 64) == 0)
            p = 1;
        else
            p = 2;
        if (w == 0 || h == 0) return;
        if (p == 0) begin
            for (int y = 0; y < h; y += 2047) begin
                int ph = (h - y > 2047) ? 2047 : h - y;
                push_exp(0, dx, dy + y, w, ph, 32'(sb + (sy + y) * sp + sx * cpp),
                         32'(db + (dy + y) * dp + dx * cpp));
            end
        end else if (p == 1) begin
            for (int y = 0; y < h; y += 1024) begin
                for (int x = 0; x < w; x += 1024) begin
                    int pw = (w - x > 1024) ? 1024 : w - x;
                    int ph = (h - y > 1024) ? 1024 : h - y;
                    push_exp(1, dx + x, dy + y, pw + (pw % 2), ph + (ph % 2),
                             32'(sb + (sy + y) * sp + (sx + x) * cpp), 32'(db));
                end
            end
        end else begin
            push_exp(2, dx, dy, w, h, 32'(sb), 32'(db));
        end
    endtask

    task automatic wait_accept();
        for (int i = 0; i < 100 && !req_ready; i++) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic send();
        req_valid = 1'b1;
        wait_accept();
    endtask

    // gathers commands until done; bp = 1 applies backpressure two cycles in three
    task automatic collect(input bit bp, input string req);
        bit seen_done = 1'b0;
        bit stall = 1'b0;
        logic [31:0] ps, pd;
        logic [15:0] px, py, pw, ph;
        got_n = 0;
        for (int cyc = 0; cyc < 5000 && !seen_done; cyc++) begin
            cmd_ready = bp ? (cyc % 3 == 2) : 1'b1;
            if (stall) begin
                check("R12", "held fields", {cmd_valid, cmd_x, cmd_y, cmd_w, cmd_h, cmd_src_off, cmd_dst_off} ==
                      {1'b1, px, py, pw, ph, ps, pd}, 1);
            end
            if (cmd_valid) check("R11", "req_ready while emitting", req_ready, 0);
            if (cmd_valid && cmd_ready) begin
                if (got_n < 64) begin
                    g_path[got_n] = int'(cmd_path); g_x[got_n] = int'(cmd_x); g_y[got_n] = int'(cmd_y);
                    g_w[got_n] = int'(cmd_w); g_h[got_n] = int'(cmd_h);
                    g_so[got_n] = cmd_src_off; g_do[got_n] = cmd_dst_off;
                end
                got_n++;
            end
            stall = cmd_valid && !cmd_ready;
            px = cmd_x; py = cmd_y; pw = cmd_w; ph = cmd_h; ps = cmd_src_off; pd = cmd_dst_off;
            if (done) begin
                seen_done = 1'b1;
                check("R11", "req_ready during done", req_ready, 0);
            end else begin
                @(negedge clk);
            end
        end
        check(req, "done seen", seen_done, 1);
        cmd_ready = 1'b1;
    endtask

    task automatic compare(input string req);
        check(req, "command count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 64; i++) begin
            check(req, $sformatf("path[%0d]", i), g_path[i], e_path[i]);
            check("R9", $sformatf("x[%0d]", i), g_x[i], e_x[i]);
            check("R9", $sformatf("y[%0d]", i), g_y[i], e_y[i]);
            check(req, $sformatf("w[%0d]", i), g_w[i], e_w[i]);
            check(req, $sformatf("h[%0d]", i), g_h[i], e_h[i]);
            check(req, $sformatf("src_off[%0d]", i), g_so[i], e_so[i]);
            check(req, $sformatf("dst_off[%0d]", i), g_do[i], e_do[i]);
        end
    endtask

    task automatic run_case(input bit bp, input string req);
        model();
        send();
        collect(bp, req);
        compare(req);
    endtask

    task automatic test_reset();
        check("R11", "reset req_ready", req_ready, 1);
        check("R11", "reset cmd_valid", cmd_valid, 0);
        check("R11", "reset done", done, 0);
    endtask

    task automatic test_linear_basic();   // R1 R5
        set_req(0, 0, 256, 256, 4, 'h1000, 'h8000, 1024, 2048, 3, 2, 5, 7, 10, 5);
        run_case(0, "R1/R5 linear basic");
    endtask

    task automatic test_linear_split();   // R4 R5
        set_req(0, 0, 256, 256, 2, 'h200, 'h400, 64, 128, 4, 1, 0, 3, 16, 5000);
        run_case(0, "R4/R5 linear split");
    endtask

    task automatic test_linear_small_surface();   // R1
        set_req(1, 1, 2, 512, 4, 'h40, 'h80, 32, 32, 0, 0, 1, 1, 2, 9);
        run_case(0, "R1 narrow surface");
        set_req(0, 1, 64, 1, 4, 'h0, 'h100, 256, 256, 2, 0, 3, 0, 20, 1);
        run_case(0, "R1 one-row surface");
    endtask

    task automatic test_swizzle_tiles();  // R2 R6 R8
        set_req(0, 1, 4096, 4096, 4, 'h100, 'h40000, 8192, 0, 1, 2, 0, 0, 2500, 1500);
        run_case(0, "R2/R6/R8 swizzle tiles");
    endtask

    task automatic test_swizzle_odd();    // R7
        set_req(0, 1, 16, 16, 2, 'h10, 'h1000, 32, 0, 1, 1, 4, 6, 3, 5);
        run_case(0, "R7 odd tile");
    endtask

    task automatic test_fallback();       // R3
        set_req(0, 1, 64, 64, 4, 'h300, 'h40020, 256, 0, 1, 2, 3, 4, 7, 9);
        run_case(0, "R3 misaligned base");
        set_req(0, 1, 64, 64, 1, 'h300, 'h40000, 256, 0, 1, 2, 3, 4, 7, 9);
        run_case(0, "R3 one byte pixels");
        set_req(1, 0, 64, 64, 4, 'h500, 'h600, 256, 256, 0, 0, 2, 2, 5, 5);
        run_case(0, "R3 swizzled source");
    endtask

    task automatic test_zero();           // R10
        set_req(0, 0, 64, 64, 4, 0, 0, 64, 64, 0, 0, 0, 0, 0, 9);
        run_case(0, "R10 zero width");
        set_req(0, 1, 64, 64, 4, 0, 0, 64, 64, 0, 0, 0, 0, 4, 0);
        run_case(0, "R10 zero height");
    endtask

    task automatic test_backpressure();   // R12
        set_req(0, 0, 256, 256, 4, 'h20, 'h40, 16, 32, 1, 0, 2, 0, 4, 4100);
        run_case(1, "R12/R4 stalled linear");
        set_req(0, 1, 4096, 4096, 2, 'h0, 'h80, 4096, 0, 0, 0, 0, 0, 1100, 30);
        run_case(1, "R12/R6 stalled swizzle");
    endtask

    task automatic test_overlap();        // R11
        set_req(0, 1, 4096, 4096, 4, 'h100, 'h40000, 8192, 0, 0, 0, 8, 8, 1030, 20);
        model();
        send();
        set_req(0, 0, 256, 256, 2, 'h10, 'h20, 64, 64, 1, 1, 1, 1, 6, 3);
        req_valid = 1'b1;
        collect(0, "R11 first job");
        compare("R11 first job");
        model();
        wait_accept();
        collect(0, "R11 queued job");
        compare("R11 queued job");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_linear_basic();
        test_linear_split();
        test_linear_small_surface();
        test_swizzle_tiles();
        test_swizzle_odd();
        test_fallback();
        test_zero();
        test_backpressure();
        test_overlap();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #4000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule